// File: doc/BRIEF.md
# Error-Rate Supply Voltage Controller

This block sets the supply voltage from the rate of timing errors. The pipeline reports timing errors on a bus of error lanes. Over a fixed window of clock cycles the block counts every lane that is high in every cycle. At the end of each window it subtracts that count from a target error count. It scales the difference by a gain and moves the voltage code in the opposite direction. When the count is below the target, the code falls and the supply drops. When the count is above the target, the code rises.

The voltage code goes to an external regulator. The regulator maps the code range onto the supply range, for example 1.1 V at the lowest code and 1.8 V at the highest. The code is held between a lower and an upper bound, and a one-cycle strobe marks each new code. The target count and the gain are sampled at the final clock edge of each window. They may change freely between windows.

Top module: `vscale_ctrl`

## Requirements
- R1: While `rst` is high, `vcode` equals CODE_INIT (120 by default) and `vcode_upd` is 0 from the next clock edge on.
- R2: After reset is released, `vcode_upd` is high for exactly one cycle every WIN_LEN clock edges. The first pulse is visible after the WIN_LEN-th edge following release.
- R3: Each error lane that is high in a cycle adds one to the window count. Several lanes high in one cycle add one each.
- R4: The window count starts from zero in every window. Errors from one window have no effect on the next update.
- R5: At the end of a window the new code is `old - gain*(err_target - count)`, with `gain` taken as an unsigned multiplier. A count below the target therefore lowers the code.
- R6: A count above the target raises the code by `gain*(count - err_target)`.
- R7: A count equal to the target leaves the code unchanged, and the strobe still pulses.
- R8: The code saturates at CODE_MAX (200 by default) and never wraps past it.
- R9: The code saturates at CODE_MIN (40 by default) and never wraps below it.
- R10: `vcode` changes only in a cycle where `vcode_upd` is high.
- R11: A reset in the middle of a window discards the partial count and restarts the window from the release of reset.
- R12: A gain of 0 leaves the code unchanged whatever the errors are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_lanes | input | LANES | Timing error flags from the pipeline, one per lane per cycle |
| err_target | input | ACC_W | Target error count per window |
| gain | input | GAIN_W | Proportional gain, unsigned multiplier |
| vcode | output | CODE_W | Voltage code for the regulator |
| vcode_upd | output | 1 | One-cycle pulse that marks a new code |

## Verification
Error flags driven before the k-th clock edge after reset release are counted in that edge's window. The update for a window is registered at that window's WIN_LEN-th edge, so the new code and the strobe appear together one register stage after the last counted cycle. The bench drives every input on a falling edge and samples on the following falling edge. It checks the strobe and the new code at the falling edge right after the WIN_LEN-th rising edge. At every earlier falling edge of the window it checks that the strobe is low and the code has not moved.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

   // width of an error count that can hold every lane of every cycle of one window
   function automatic int unsigned count_bits(input int unsigned lanes, input int unsigned win);
      return $clog2(lanes * win + 1);
   endfunction

endpackage

// File: rtl/vsc_popcount.sv
module vsc_popcount #(
   parameter int unsigned LANES = 4,
   parameter int unsigned OUT_W = 3
) (
   input  logic [LANES-1:0] bits,
   output logic [OUT_W-1:0] count
);

   logic [OUT_W-1:0] partial [LANES+1];

   assign partial[0] = '0;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign partial[g+1] = partial[g] + OUT_W'(bits[g]);
   end

   assign count = partial[LANES];

endmodule

// File: rtl/vsc_window.sv
module vsc_window #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned WIN_LEN = 16,
   parameter int unsigned ACC_W   = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LANES-1:0] err_lanes,
   output logic             win_last,
   output logic [ACC_W-1:0] win_total
);

   localparam int unsigned CNT_W = $clog2(WIN_LEN);
   localparam int unsigned POP_W = $clog2(LANES + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

   logic [CNT_W-1:0] cyc_q;
   logic [ACC_W-1:0] acc_q;
   logic [POP_W-1:0] pop_now;

   vsc_popcount #(
      .LANES(LANES),
      .OUT_W(POP_W)
   ) u_pop (
      .bits (err_lanes),
      .count(pop_now)
   );

   assign win_last  = (cyc_q == LAST_IDX);
   assign win_total = acc_q + ACC_W'(pop_now);

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q <= '0;
         acc_q <= '0;
      end else if (win_last) begin
         cyc_q <= '0;
         acc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
         acc_q <= win_total;
      end
   end

endmodule

// File: rtl/vsc_step.sv
module vsc_step #(
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned ACC_W    = 7,
   parameter int unsigned GAIN_W   = 4,
   parameter int unsigned CODE_MIN = 40,
   parameter int unsigned CODE_MAX = 200
) (
   input  logic [CODE_W-1:0] code_cur,
   input  logic [ACC_W-1:0]  target,
   input  logic [ACC_W-1:0]  sampled,
   input  logic [GAIN_W-1:0] gain,
   output logic [CODE_W-1:0] code_nxt
);

   localparam int unsigned DIFF_W = ACC_W + 1;
   localparam int unsigned PROD_W = DIFF_W + GAIN_W + 1;
   localparam int unsigned WIDE_W = ((CODE_W + 1 > PROD_W) ? CODE_W + 1 : PROD_W) + 1;
   localparam logic signed [WIDE_W-1:0] LO_S = WIDE_W'(CODE_MIN);
   localparam logic signed [WIDE_W-1:0] HI_S = WIDE_W'(CODE_MAX);

   logic signed [DIFF_W-1:0] diff;
   logic signed [PROD_W-1:0] step;
   logic signed [WIDE_W-1:0] cur_w;
   logic signed [WIDE_W-1:0] raw;

   always_comb begin
      diff  = $signed({1'b0, target}) - $signed({1'b0, sampled});
      step  = PROD_W'(diff) * $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
      cur_w = $signed({{(WIDE_W-CODE_W){1'b0}}, code_cur});
      raw   = cur_w - WIDE_W'(step);
      if (raw < LO_S)
         code_nxt = CODE_W'(CODE_MIN);
      else if (raw > HI_S)
         code_nxt = CODE_W'(CODE_MAX);
      else
         code_nxt = raw[CODE_W-1:0];
   end

endmodule

// File: rtl/vscale_ctrl.sv
module vscale_ctrl
   import vsc_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned WIN_LEN   = 16,
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned CODE_MIN  = 40,
   parameter int unsigned CODE_MAX  = 200,
   parameter int unsigned CODE_INIT = 120,
   parameter int unsigned GAIN_W    = 4,
   localparam int unsigned ACC_W    = count_bits(LANES, WIN_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LANES-1:0]  err_lanes,
   input  logic [ACC_W-1:0]  err_target,
   input  logic [GAIN_W-1:0] gain,
   output logic [CODE_W-1:0] vcode,
   output logic              vcode_upd
);

   if (WIN_LEN < 2) begin : g_bad_win
      $error("vscale_ctrl: WIN_LEN must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("vscale_ctrl: LANES must be at least 1");
   end
   if (CODE_MIN > CODE_MAX) begin : g_bad_range
      $error("vscale_ctrl: CODE_MIN above CODE_MAX");
   end
   if (CODE_MAX >= (1 << CODE_W)) begin : g_bad_width
      $error("vscale_ctrl: CODE_MAX does not fit CODE_W");
   end
   if (CODE_INIT < CODE_MIN || CODE_INIT > CODE_MAX) begin : g_bad_init
      $error("vscale_ctrl: CODE_INIT outside code range");
   end

   logic              win_last;
   logic [ACC_W-1:0]  win_total;
   logic [CODE_W-1:0] code_nxt;
   logic [CODE_W-1:0] code_q;
   logic              upd_q;

   vsc_window #(
      .LANES  (LANES),
      .WIN_LEN(WIN_LEN),
      .ACC_W  (ACC_W)
   ) u_win (
      .clk      (clk),
      .rst      (rst),
      .err_lanes(err_lanes),
      .win_last (win_last),
      .win_total(win_total)
   );

   vsc_step #(
      .CODE_W  (CODE_W),
      .ACC_W   (ACC_W),
      .GAIN_W  (GAIN_W),
      .CODE_MIN(CODE_MIN),
      .CODE_MAX(CODE_MAX)
   ) u_step (
      .code_cur(code_q),
      .target  (err_target),
      .sampled (win_total),
      .gain    (gain),
      .code_nxt(code_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= CODE_W'(CODE_INIT);
         upd_q  <= 1'b0;
      end else begin
         upd_q <= win_last;
         if (win_last)
            code_q <= code_nxt;
      end
   end

   assign vcode     = code_q;
   assign vcode_upd = upd_q;

endmodule

// File: rtl/vscale_ctrl_chk.sv
module vscale_ctrl_chk #(
   parameter int unsigned WIN_LEN   = 16,
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned CODE_MIN  = 40,
   parameter int unsigned CODE_MAX  = 200,
   parameter int unsigned CODE_INIT = 120
) (
   input logic              clk,
   input logic              rst,
   input logic [CODE_W-1:0] vcode,
   input logic              vcode_upd
);

   localparam int unsigned GAP_W = $clog2(WIN_LEN + 1) + 1;

   // cycles since reset release or since the last strobe
   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (rst)
         gap_q <= '0;
      else if (vcode_upd)
         gap_q <= GAP_W'(1);
      else if (gap_q <= GAP_W'(WIN_LEN))
         gap_q <= gap_q + 1'b1;
   end

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (vcode == CODE_W'(CODE_INIT) && !vcode_upd));

   a_r2_strobe_period: assert property (@(posedge clk) disable iff (rst)
      vcode_upd |-> gap_q == GAP_W'(WIN_LEN));

   a_r2_no_missed_strobe: assert property (@(posedge clk) disable iff (rst)
      gap_q <= GAP_W'(WIN_LEN));

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      vcode_upd |=> !vcode_upd);

   a_r8_code_max: assert property (@(posedge clk) disable iff (rst)
      vcode <= CODE_W'(CODE_MAX));

   a_r9_code_min: assert property (@(posedge clk) disable iff (rst)
      vcode >= CODE_W'(CODE_MIN));

   a_r10_code_held: assert property (@(posedge clk) disable iff (rst)
      !vcode_upd |=> (!vcode_upd || 1'b1) && ($stable(vcode) || vcode_upd));

endmodule

bind vscale_ctrl vscale_ctrl_chk #(
   .WIN_LEN  (WIN_LEN),
   .CODE_W   (CODE_W),
   .CODE_MIN (CODE_MIN),
   .CODE_MAX (CODE_MAX),
   .CODE_INIT(CODE_INIT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .vcode    (vcode),
   .vcode_upd(vcode_upd)
);

// File: tb/vscale_ctrl_bench.sv
module vscale_ctrl_bench;

   localparam int LANES   = 4;
   localparam int WIN_LEN = 16;
   localparam int CODE_W  = 8;
   localparam int C_MIN   = 40;
   localparam int C_MAX   = 200;
   localparam int C_INIT  = 120;
   localparam int GAIN_W  = 4;
   localparam int ACC_W   = $clog2(LANES * WIN_LEN + 1);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [LANES-1:0]  err_lanes = '0;
   logic [ACC_W-1:0]  err_target = '0;
   logic [GAIN_W-1:0] gain = '0;
   logic [CODE_W-1:0] vcode;
   logic              vcode_upd;

   int checks   = 0;
   int failures = 0;
   int exp_code = C_INIT;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   vscale_ctrl u_vscale_ctrl (
      .clk       (clk),
      .rst       (rst),
      .err_lanes (err_lanes),
      .err_target(err_target),
      .gain      (gain),
      .vcode     (vcode),
      .vcode_upd (vcode_upd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_next(input int cur, input int tgt, input int cnt, input int g);
      int v;
      v = cur - g * (tgt - cnt);
      if (v < C_MIN) v = C_MIN;
      if (v > C_MAX) v = C_MAX;
      return v;
   endfunction

   // One full window: pattern pat for the first n cycles, idle afterwards.
   // Called at a falling edge that sits on a window boundary.
   task automatic run_window(input logic [LANES-1:0] pat, input int n,
                             input int tgt, input int g, input string req);
      int cnt;
      cnt = n * $countones(pat);
      err_target = ACC_W'(tgt);
      gain = GAIN_W'(g);
      for (int i = 0; i < WIN_LEN; i++) begin
         err_lanes = (i < n) ? pat : '0;
         @(negedge clk);
         if (i < WIN_LEN - 1) begin
            check(vcode_upd == 1'b0, "R2 strobe low inside window", vcode_upd, 0);
            check(vcode == CODE_W'(exp_code), "R10 code held inside window", vcode, exp_code);
         end
      end
      err_lanes = '0;
      exp_code = model_next(exp_code, tgt, cnt, g);
      check(vcode_upd == 1'b1, "R2 strobe at window end", vcode_upd, 1);
      check(vcode == CODE_W'(exp_code), req, vcode, exp_code);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      err_lanes = '0;
      repeat (3) @(negedge clk);
      check(vcode == CODE_W'(C_INIT), "R1 code during reset", vcode, C_INIT);
      check(vcode_upd == 1'b0, "R1 strobe during reset", vcode_upd, 0);
      rst = 1'b0;
      exp_code = C_INIT;
   endtask

   task automatic t_equal();
      run_window(4'b0001, 8, 8, 3, "R7 count equal to target keeps code");
   endtask

   task automatic t_lower();
      run_window(4'b0000, 0, 8, 2, "R5 fewer errors lower code");
   endtask

   task automatic t_multi_lane();
      run_window(4'b1111, 5, 8, 1, "R3 R6 every lane counts, more errors raise code");
   endtask

   task automatic t_clear();
      run_window(4'b1111, 10, 8, 0, "R12 zero gain keeps code");
      run_window(4'b0011, 4, 8, 2, "R4 count restarts each window");
   endtask

   task automatic t_max();
      run_window(4'b1111, 16, 8, 15, "R8 saturate at max");
      run_window(4'b1111, 16, 8, 15, "R8 stays at max without wrap");
   endtask

   task automatic t_min();
      run_window(4'b0000, 0, 127, 15, "R9 saturate at min");
      run_window(4'b0000, 0, 127, 15, "R9 stays at min without wrap");
      run_window(4'b0101, 3, 2, 1, "R6 raise from min");
   endtask

   task automatic t_mid_reset();
      err_lanes = 4'b1111;
      err_target = ACC_W'(8);
      gain = GAIN_W'(3);
      repeat (7) @(negedge clk);
      rst = 1'b1;
      err_lanes = '0;
      repeat (2) @(negedge clk);
      check(vcode == CODE_W'(C_INIT), "R11 code back to init after mid-window reset", vcode, C_INIT);
      check(vcode_upd == 1'b0, "R11 no strobe after mid-window reset", vcode_upd, 0);
      rst = 1'b0;
      exp_code = C_INIT;
      run_window(4'b0001, 8, 8, 3, "R11 partial count discarded, window restarted");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      do_reset();
      t_equal();
      t_lower();
      t_multi_lane();
      t_clear();
      t_max();
      t_min();
      t_mid_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog expired, actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule